// File: doc/BRIEF.md
# Bit-Aligned Block Transfer Engine

This block moves a rectangle of 16-bit words from a source area of memory to a destination area. Each destination word becomes a logic function of its old value and a source word that has been shifted to an arbitrary bit position. Software hands the engine a full description of the rectangle on a set of plain configuration pins: source and destination start addresses, a shift amount, a height in lines, a width in words, two edge masks, a signed line step (warp) for source and destination, a logic function code, and two option bits for horizontal direction and source inversion. A one-cycle `start` pulse latches all of them, the engine walks the rectangle on its own, and `done` pulses once when the final word has gone back to memory.

The engine masters a single word-wide memory request channel with valid/ready handshaking. Every request (read or write) is held, with address, write flag and write data unchanged, until the cycle in which `mem_ready` is high; that cycle is the transfer. For a read, `mem_rdata` must carry the addressed word in that same cycle. The memory may stall any request for any number of cycles. Addresses count words, not bytes, and wrap modulo 2^AW.

Each destination word takes three transfers in a fixed order: read the source word, read the destination word, write the merged word. Lines are walked in ascending or descending word order, and the per-line warps (distance from one line start to the next, two's complement) choose whether lines walk down or up the memory, which lets overlapping moves be ordered safely.

Top module: `bitblt_engine`

## Requirements
- R1: While `rst_n` is low and after its release until the first `start`, `done` and `mem_valid` are 0.
- R2: Per destination word the engine issues exactly three accepted transfers in the order source read, destination read, destination write; while `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R3: `logic_op` selects the merge of destination D with aligned source A: 0 gives D AND A, 1 gives D OR A, 2 gives D XOR A, 3 gives D OR A (fast OR), and 4, 5, 6 and 7 give A (copy).
- R4: With `src_invert` = 1 each source word is bit-inverted as it is read, before shifting; with `logic_op` = 3 both `src_invert` and `dir_down` are ignored, so fast OR always behaves as OR with true source and ascending order.
- R5: Word k (k = 0 .. width-1, in processing order) of a line uses offset k from the line start when `dir_down` = 0 and offset width-1-k when `dir_down` = 1, for both source and destination.
- R6: With shift s, carry C (the previously processed, possibly inverted, source word of the same line, 0 for the first word) and current source S, the aligned word is the upper 16 bits of {S, C} shifted left by s when `dir_down` = 0, and the lower 16 bits of {C, S} shifted right by s when `dir_down` = 1.
- R7: The first processed word of each line is merged under `mask_first`, the last under `mask_last`, both ANDed when width is 1, and inner words under all ones; where the mask bit is 0 the destination bit keeps its old value.
- R8: After each line the source and destination line starts advance by `src_warp` and `dst_warp` (two's complement, modulo 2^AW), so negative warps walk lines toward lower addresses.
- R9: `done` is 1 for exactly one cycle, in the cycle after the last write is accepted; with height 0 or width 0 no transfer is issued and `done` is 1 in the cycle after `start`; a run of height H and width W writes exactly H*W words.
- R10: A same-line overlapping copy whose destination lies one word above the source gives the original source contents at the destination when run with `dir_down` = 1.
- R11: All configuration inputs are latched on the accepted `start`; changing them, or pulsing `start`, while a transfer is running does not change the words written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the current configuration (ignored while busy) |
| src_base | input | AW | Word address of the first source line start |
| dst_base | input | AW | Word address of the first destination line start |
| src_warp | input | AW | Signed distance between successive source line starts |
| dst_warp | input | AW | Signed distance between successive destination line starts |
| height | input | HW | Number of lines |
| width | input | WW | Number of source words read per line |
| shift | input | $clog2(DW) | Bit shift applied to the source stream |
| mask_first | input | DW | Write mask of the first processed word of each line |
| mask_last | input | DW | Write mask of the last processed word of each line |
| logic_op | input | 3 | Merge function code (see R3) |
| dir_down | input | 1 | 1: descending word order within a line |
| src_invert | input | 1 | 1: invert source words |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1: write request, 0: read request |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the accepting cycle of a read |

## Verification
The merge is swept over every function code, both inversion settings, both directions and all sixteen shifts on a three-word, two-line rectangle whose source and destination do not overlap, which separates the functions from each other, true from inverted source, carry entering from the left or from the right, and an off-by-one shift. A second sweep varies the width from one to five with distinct edge masks and negative warps, telling a first-word mask from a last-word mask, the single-word mask conjunction, and upward from downward line stepping. A right-panning overlapped copy in descending order separates a correct processing order from one that reads already overwritten words, and a run whose inputs are scrambled mid-flight shows that only the latched configuration matters. Memory stalls are drawn from a pseudo-random pattern so that every request is exercised under back-pressure.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // merge function codes (codes 5..7 act as copy)
  localparam logic [2:0] OP_AND   = 3'd0;
  localparam logic [2:0] OP_OR    = 3'd1;
  localparam logic [2:0] OP_XOR   = 3'd2;
  localparam logic [2:0] OP_FOR   = 3'd3;
  localparam logic [2:0] OP_COPY  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_SRC,
    S_RD_DST,
    S_WRITE,
    S_FIN
  } bb_state_e;

endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl import bb_pkg::*; #(
  parameter int HW = 8,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [HW-1:0] height,
  input  logic [WW-1:0] width,
  input  logic          mem_ready,
  output logic          load,
  output logic          req_valid,
  output logic          req_we,
  output logic          use_dst,
  output logic          cap_src,
  output logic          cap_dst,
  output logic          word_done,
  output logic          line_done,
  output logic          first_word,
  output logic          last_word,
  output logic [WW-1:0] word_idx,
  output logic [WW-1:0] width_q,
  output logic          fin
);

  bb_state_e     state_q;
  logic [HW-1:0] height_q;
  logic [HW-1:0] line_idx;
  logic          last_line;
  logic          empty_job;

  assign load       = (state_q == S_IDLE) && start;
  assign empty_job  = (height == '0) || (width == '0);
  assign first_word = (word_idx == '0);
  assign last_word  = (word_idx == width_q - WW'(1));
  assign last_line  = (line_idx == height_q - HW'(1));

  assign req_valid  = (state_q == S_RD_SRC) || (state_q == S_RD_DST) || (state_q == S_WRITE);
  assign req_we     = (state_q == S_WRITE);
  assign use_dst    = (state_q == S_RD_DST) || (state_q == S_WRITE);
  assign cap_src    = (state_q == S_RD_SRC) && mem_ready;
  assign cap_dst    = (state_q == S_RD_DST) && mem_ready;
  assign word_done  = (state_q == S_WRITE) && mem_ready;
  assign line_done  = word_done && last_word;
  assign fin        = (state_q == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      height_q <= '0;
      width_q  <= '0;
      line_idx <= '0;
      word_idx <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            height_q <= height;
            width_q  <= width;
            line_idx <= '0;
            word_idx <= '0;
            state_q  <= empty_job ? S_FIN : S_RD_SRC;
          end
        end
        S_RD_SRC: if (mem_ready) state_q <= S_RD_DST;
        S_RD_DST: if (mem_ready) state_q <= S_WRITE;
        S_WRITE: begin
          if (mem_ready) begin
            if (last_word) begin
              word_idx <= '0;
              if (last_line) begin
                state_q <= S_FIN;
              end else begin
                line_idx <= line_idx + HW'(1);
                state_q  <= S_RD_SRC;
              end
            end else begin
              word_idx <= word_idx + WW'(1);
              state_q  <= S_RD_SRC;
            end
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R9: an empty job finishes right after start with no request
  p_empty_job_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && empty_job) |=> (fin && !req_valid));

  // R5: the word index never leaves the latched width while requesting
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (word_idx < width_q));

endmodule

// File: rtl/bb_addr_gen.sv
module bb_addr_gen #(
  parameter int AW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [AW-1:0] src_warp,
  input  logic [AW-1:0] dst_warp,
  input  logic          next_line,
  input  logic          dir_down,
  input  logic [WW-1:0] width_q,
  input  logic [WW-1:0] word_idx,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);

  logic [AW-1:0] src_line_q, dst_line_q;
  logic [AW-1:0] src_step_q, dst_step_q;
  logic [WW-1:0] offset;

  assign offset   = dir_down ? (width_q - WW'(1) - word_idx) : word_idx;
  assign src_addr = src_line_q + AW'(offset);
  assign dst_addr = dst_line_q + AW'(offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_line_q <= '0;
      dst_line_q <= '0;
      src_step_q <= '0;
      dst_step_q <= '0;
    end else if (load) begin
      src_line_q <= src_base;
      dst_line_q <= dst_base;
      src_step_q <= src_warp;
      dst_step_q <= dst_warp;
    end else if (next_line) begin
      src_line_q <= src_line_q + src_step_q;
      dst_line_q <= dst_line_q + dst_step_q;
    end
  end

  // R8: a finished line moves both line starts by their warp
  p_line_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (next_line && !load) |=> (src_line_q == $past(src_line_q) + $past(src_step_q))
                          && (dst_line_q == $past(dst_line_q) + $past(dst_step_q)));

endmodule

// File: rtl/bb_merge.sv
module bb_merge import bb_pkg::*; #(
  parameter int DW  = 16,
  parameter int SHW = 4
) (
  input  logic [DW-1:0]  src_word,
  input  logic [DW-1:0]  carry_word,
  input  logic [DW-1:0]  dst_word,
  input  logic [SHW-1:0] shift,
  input  logic           dir_down,
  input  logic [2:0]     op,
  input  logic           first_word,
  input  logic           last_word,
  input  logic [DW-1:0]  mask_first,
  input  logic [DW-1:0]  mask_last,
  output logic [DW-1:0]  result
);

  logic [2*DW-1:0] funnel;
  logic [DW-1:0]   aligned;
  logic [DW-1:0]   combined;
  logic [DW-1:0]   mask;

  // funnel shifter: carry enters from the side the walk came from
  always_comb begin
    if (dir_down) begin
      funnel  = {carry_word, src_word} >> shift;
      aligned = funnel[DW-1:0];
    end else begin
      funnel  = {src_word, carry_word} << shift;
      aligned = funnel[2*DW-1:DW];
    end
  end

  always_comb begin
    mask = '1;
    if (first_word) mask = mask & mask_first;
    if (last_word)  mask = mask & mask_last;
  end

  always_comb begin
    unique case (op)
      OP_AND:         combined = dst_word & aligned;
      OP_OR, OP_FOR:  combined = dst_word | aligned;
      OP_XOR:         combined = dst_word ^ aligned;
      default:        combined = aligned;
    endcase
  end

  assign result = (combined & mask) | (dst_word & ~mask);

endmodule

// File: rtl/bitblt_engine.sv
module bitblt_engine import bb_pkg::*; #(
  parameter  int DW  = 16,
  parameter  int AW  = 16,
  parameter  int HW  = 8,
  parameter  int WW  = 8,
  localparam int SHW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  src_base,
  input  logic [AW-1:0]  dst_base,
  input  logic [AW-1:0]  src_warp,
  input  logic [AW-1:0]  dst_warp,
  input  logic [HW-1:0]  height,
  input  logic [WW-1:0]  width,
  input  logic [SHW-1:0] shift,
  input  logic [DW-1:0]  mask_first,
  input  logic [DW-1:0]  mask_last,
  input  logic [2:0]     logic_op,
  input  logic           dir_down,
  input  logic           src_invert,
  output logic           done,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);

  logic          load, use_dst, cap_src, cap_dst, word_done, line_done;
  logic          first_word, last_word;
  logic [WW-1:0] word_idx, width_q;
  logic [AW-1:0] src_addr, dst_addr;

  logic [SHW-1:0] shift_q;
  logic [2:0]     op_q;
  logic           down_q, inv_q;
  logic [DW-1:0]  mfirst_q, mlast_q;
  logic [DW-1:0]  src_q, dst_q, carry_q;
  logic           fast_or;

  // fast OR forces ascending order and true source
  assign fast_or = (logic_op == OP_FOR);

  bb_ctrl #(.HW(HW), .WW(WW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .height     (height),
    .width      (width),
    .mem_ready  (mem_ready),
    .load       (load),
    .req_valid  (mem_valid),
    .req_we     (mem_we),
    .use_dst    (use_dst),
    .cap_src    (cap_src),
    .cap_dst    (cap_dst),
    .word_done  (word_done),
    .line_done  (line_done),
    .first_word (first_word),
    .last_word  (last_word),
    .word_idx   (word_idx),
    .width_q    (width_q),
    .fin        (done)
  );

  bb_addr_gen #(.AW(AW), .WW(WW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .src_warp  (src_warp),
    .dst_warp  (dst_warp),
    .next_line (line_done),
    .dir_down  (down_q),
    .width_q   (width_q),
    .word_idx  (word_idx),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr)
  );

  bb_merge #(.DW(DW), .SHW(SHW)) u_merge (
    .src_word   (src_q),
    .carry_word (carry_q),
    .dst_word   (dst_q),
    .shift      (shift_q),
    .dir_down   (down_q),
    .op         (op_q),
    .first_word (first_word),
    .last_word  (last_word),
    .mask_first (mfirst_q),
    .mask_last  (mlast_q),
    .result     (mem_wdata)
  );

  assign mem_addr = use_dst ? dst_addr : src_addr;

  // latched configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q  <= '0;
      op_q     <= OP_COPY;
      down_q   <= 1'b0;
      inv_q    <= 1'b0;
      mfirst_q <= '1;
      mlast_q  <= '1;
    end else if (load) begin
      shift_q  <= shift;
      op_q     <= logic_op;
      down_q   <= dir_down & ~fast_or;
      inv_q    <= src_invert & ~fast_or;
      mfirst_q <= mask_first;
      mlast_q  <= mask_last;
    end
  end

  // word registers and the per-line carry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      carry_q <= '0;
    end else begin
      if (cap_src) src_q <= inv_q ? ~mem_rdata : mem_rdata;
      if (cap_dst) dst_q <= mem_rdata;
      if (load || line_done) carry_q <= '0;
      else if (word_done)    carry_q <= src_q;
    end
  end

  // R2: a stalled request keeps all its fields
  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

  // R2: a write is always preceded by an accepted destination read
  p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !$past(mem_we && mem_valid)) |-> $past(mem_valid && mem_ready && !mem_we));

  // R6: every line starts with an empty carry
  p_carry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !use_dst && first_word) |-> (carry_q == '0));

  // R1: nothing is requested while done is shown
  p_quiet_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);

endmodule

// File: tb/tb_bitblt_engine.sv
module tb_bitblt_engine;

  localparam int DW   = 16;
  localparam int AW   = 8;
  localparam int HW   = 8;
  localparam int WW   = 8;
  localparam int MEMN = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] src_base, dst_base, src_warp, dst_warp;
  logic [HW-1:0] height;
  logic [WW-1:0] width;
  logic [3:0]    shift;
  logic [DW-1:0] mask_first, mask_last;
  logic [2:0]    logic_op;
  logic          dir_down, src_invert;
  logic          done, mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  bitblt_engine #(.DW(DW), .AW(AW), .HW(HW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base), .src_warp(src_warp), .dst_warp(dst_warp),
    .height(height), .width(width), .shift(shift),
    .mask_first(mask_first), .mask_last(mask_last),
    .logic_op(logic_op), .dir_down(dir_down), .src_invert(src_invert),
    .done(done), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] mem  [MEMN];
  logic [DW-1:0] refm [MEMN];
  logic [DW-1:0] orig [MEMN];

  assign mem_rdata = mem[mem_addr];

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, stall generator and protocol monitor
  logic [7:0]    lfsr = 8'hA5;
  bit            stall_en = 1'b1;
  bit            stall_prev = 1'b0;
  logic [AW-1:0] p_addr;
  logic          p_we;
  logic [DW-1:0] p_wdata;
  bit            prev_wr_acc = 1'b0;
  bit            count_mode = 1'b0;
  int            phase = 0;
  int            wr_count = 0;
  int            hold_err = 0, order_err = 0, done_err = 0;

  always @(negedge clk) begin
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = !stall_en || (lfsr[1:0] != 2'b00);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (stall_prev && !(mem_valid && mem_addr == p_addr && mem_we == p_we
                          && (!p_we || mem_wdata == p_wdata)))
        hold_err++;
      if (mem_valid && mem_ready) begin
        if (mem_we != (phase == 2)) order_err++;
        phase = (phase == 2) ? 0 : phase + 1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_count++;
        end
      end
      if (done && count_mode && !prev_wr_acc) done_err++;
      prev_wr_acc = mem_valid && mem_ready && mem_we;
      stall_prev  = mem_valid && !mem_ready;
      p_addr      = mem_addr;
      p_we        = mem_we;
      p_wdata     = mem_wdata;
    end
  end

  // expected result from the requirement formulas
  task automatic model(input logic [AW-1:0] sb, input logic [AW-1:0] db,
                       input logic [AW-1:0] sw, input logic [AW-1:0] dw,
                       input int h, input int w, input int sh, input int fn,
                       input bit dc, input bit iv,
                       input logic [DW-1:0] mf, input logic [DW-1:0] ml);
    bit            fast, ed, ei;
    logic [AW-1:0] sl, dl, sa, da;
    logic [DW-1:0] c, s, d, al, f, m;
    logic [31:0]   t;
    int            off;
    fast = (fn == 3);
    ed   = dc && !fast;
    ei   = iv && !fast;
    sl   = sb;
    dl   = db;
    for (int l = 0; l < h; l++) begin
      c = '0;
      for (int k = 0; k < w; k++) begin
        off = ed ? (w - 1 - k) : k;
        sa  = sl + AW'(off);
        da  = dl + AW'(off);
        s   = refm[sa];
        if (ei) s = ~s;
        d   = refm[da];
        if (ed) begin
          t  = {c, s} >> sh;
          al = t[15:0];
        end else begin
          t  = {s, c} << sh;
          al = t[31:16];
        end
        case (fn)
          0:       f = d & al;
          1, 3:    f = d | al;
          2:       f = d ^ al;
          default: f = al;
        endcase
        m = '1;
        if (k == 0)     m = m & mf;
        if (k == w - 1) m = m & ml;
        refm[da] = (f & m) | (d & ~m);
        c = s;
      end
      sl = sl + sw;
      dl = dl + dw;
    end
  endtask

  task automatic run(input string tag,
                     input logic [AW-1:0] sb, input logic [AW-1:0] db,
                     input logic [AW-1:0] sw, input logic [AW-1:0] dw,
                     input int h, input int w, input int sh, input int fn,
                     input bit dc, input bit iv,
                     input logic [DW-1:0] mf, input logic [DW-1:0] ml,
                     input int seed, input bit perturb);
    int cyc;
    int mism;
    int first_bad;
    @(negedge clk);
    for (int i = 0; i < MEMN; i++) begin
      mem[i]  = DW'(i * 40503 + seed * 7919) ^ DW'(i << 5);
      refm[i] = mem[i];
      orig[i] = mem[i];
    end
    model(sb, db, sw, dw, h, w, sh, fn, dc, iv, mf, ml);
    phase      = 0;
    wr_count   = 0;
    count_mode = (h > 0) && (w > 0);
    src_base   = sb;  dst_base = db;  src_warp = sw;  dst_warp = dw;
    height     = HW'(h);  width = WW'(w);  shift = 4'(sh);
    logic_op   = 3'(fn);  dir_down = dc;  src_invert = iv;
    mask_first = mf;  mask_last = ml;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 0;
    if (perturb) begin
      @(negedge clk);
      src_base = 8'h33; dst_base = 8'h77; src_warp = 8'h01; dst_warp = 8'hFF;
      height = 8'd9; width = 8'd1; shift = 4'd9; logic_op = 3'd2;
      dir_down = !dc; src_invert = !iv; mask_first = 16'h0001; mask_last = 16'h8000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
    end
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R9", {tag, " completion seen"}, int'(done), 1);
    if (!count_mode)
      check(cyc == 0, "R9", {tag, " empty job done latency"}, cyc, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", {tag, " done width one cycle"}, int'(done), 0);
    check(wr_count == h * w, "R9", {tag, " write count"}, wr_count, h * w);
    mism      = 0;
    first_bad = -1;
    for (int i = 0; i < MEMN; i++) begin
      if (mem[i] !== refm[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (first_bad < 0)
      check(1'b1, tag, "memory image", 0, 0);
    else
      check(1'b0, tag, $sformatf("memory word %0d", first_bad),
            int'(mem[first_bad]), int'(refm[first_bad]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    src_base = '0; dst_base = '0; src_warp = '0; dst_warp = '0;
    height = '0; width = '0; shift = '0; logic_op = '0;
    dir_down = 1'b0; src_invert = 1'b0; mask_first = '1; mask_last = '1;
    repeat (3) @(negedge clk);
    // R1: quiet in reset
    check(done == 1'b0,      "R1", "done in reset",      int'(done), 0);
    check(mem_valid == 1'b0, "R1", "mem_valid in reset", int'(mem_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0,      "R1", "done after reset",      int'(done), 0);
    check(mem_valid == 1'b0, "R1", "mem_valid after reset", int'(mem_valid), 0);

    // R3 R4 R5 R6: every function, inversion, direction and shift
    for (int fn = 0; fn < 8; fn++)
      for (int iv = 0; iv < 2; iv++)
        for (int dc = 0; dc < 2; dc++)
          for (int sh = 0; sh < 16; sh++)
            run("R3 R4 R5 R6 sweep", 8'd16, 8'd100, 8'd8, 8'd8, 2, 3, sh, fn,
                dc[0], iv[0], 16'h7FFE, 16'hFF0F, fn * 64 + sh, 1'b0);

    // R7 R8: widths with distinct edge masks and upward line walk
    for (int w = 1; w <= 5; w++)
      for (int dc = 0; dc < 2; dc++)
        run("R7 R8 width sweep", 8'd200, 8'd120, 8'hF6, 8'hF9, 3, w, 5, 4,
            dc[0], 1'b0, 16'h0FF3, 16'hC3F0, w * 3 + dc, 1'b0);
    for (int w = 1; w <= 3; w++)
      run("R7 R8 xor downward", 8'd10, 8'd90, 8'd12, 8'd20, 4, w, 3, 2,
          1'b0, 1'b1, 16'h00FF, 16'hF00F, 50 + w, 1'b0);

    // R10: right pan inside one line, descending order
    run("R10 pan copy", 8'd40, 8'd41, 8'd16, 8'd16, 2, 6, 0, 4,
        1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 77, 1'b0);
    for (int k = 0; k < 6; k++)
      check(mem[41 + k] == orig[40 + k], "R10", $sformatf("panned word %0d", k),
            int'(mem[41 + k]), int'(orig[40 + k]));

    // R9: empty jobs
    run("R9 zero height", 8'd16, 8'd100, 8'd8, 8'd8, 0, 3, 2, 1,
        1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 5, 1'b0);
    run("R9 zero width", 8'd16, 8'd100, 8'd8, 8'd8, 2, 0, 2, 1,
        1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 6, 1'b0);

    // R11: inputs scrambled and start pulsed mid-run
    run("R11 latched config", 8'd30, 8'd150, 8'd7, 8'd9, 3, 4, 6, 0,
        1'b1, 1'b1, 16'h3FFC, 16'hFF00, 91, 1'b1);

    // R2 with free-running memory, then the protocol tallies
    stall_en = 1'b0;
    run("R2 no stall", 8'd16, 8'd100, 8'd8, 8'd8, 2, 4, 11, 1,
        1'b0, 1'b0, 16'hFFFF, 16'h7FFF, 13, 1'b0);
    check(hold_err == 0,  "R2", "stalled request changed", hold_err, 0);
    check(order_err == 0, "R2", "transfer order errors",  order_err, 0);
    check(done_err == 0,  "R9", "done not after last write", done_err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule